// File: doc/BRIEF.md
# SD Card SPI-Mode Block Read Engine

This block pulls one or more fixed-size data blocks from an SD card in SPI mode once a read command has already been issued. For every block it clocks bytes out of the card through an external byte-exchange shifter. It keeps doing so until the start token 0xFE appears. It then forwards the payload bytes on a valid/ready stream. Finally it collects the two trailing CRC bytes and compares them against a CRC16-CCITT computed locally over the payload.

A transfer begins with a one-cycle `start` pulse. That pulse latches the block count, the block size, the token-hunt limit and the CRC-check enable. The transfer ends with a one-cycle `done` pulse. A missing token ends the transfer early with `timeout_err`. A CRC mismatch ends it early with `crc_err`. The byte-exchange side uses a request/complete handshake: `xfer_req` stays high while the engine wants a byte. The shifter answers with a one-cycle `xfer_done` that carries the received byte on `xfer_rx`. The engine always transmits 0xFF.

Top module: `sd_blk_reader`

## Requirements
- R1: After reset, `xfer_req`, `out_valid` and `done` are low, and both error flags are clear.
- R2: Before each block, every received byte other than 0xFE is discarded and never appears on `out_data`. The first 0xFE begins the payload.
- R3: If `to_limit` bytes in a row (a limit of 0 behaves like 1) arrive without a 0xFE during a hunt, the engine sets `timeout_err`, pulses `done` and requests no further bytes.
- R4: Exactly `blk_size` payload bytes per block appear on `out_data`, in arrival order. Each byte is transferred when `out_valid` and `out_ready` are both high, and `out_data` holds steady while `out_valid` waits for `out_ready`.
- R5: While a payload byte waits on the output (`out_valid` high), no byte exchange is requested.
- R6: After the payload, two CRC bytes are read, high byte first. These are compared with CRC16 over the payload (polynomial 0x1021, initial value 0, MSB first). With `crc_chk_en` high, a mismatch sets `crc_err` and pulses `done` right after the low CRC byte, and no further bytes are read.
- R7: With `crc_chk_en` low, the CRC bytes are still read, but a mismatch has no effect: no error is flagged and the remaining blocks follow.
- R8: Blocks follow one another until `blk_count` blocks are complete. `done` is a single-cycle pulse after the final byte. The error flags stay set until the next accepted `start`, which clears them.
- R9: A `start` with `blk_count` of 0 pulses `done` without any byte exchange and without any error.
- R10: `start` is ignored while a transfer is in progress. The parameters latched at the accepted `start` govern the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| blk_count | input | CNT_W | Number of blocks to read |
| blk_size | input | SZ_W | Payload bytes per block |
| to_limit | input | TO_W | Maximum bytes examined per token hunt |
| crc_chk_en | input | 1 | Enable the CRC comparison |
| xfer_req | output | 1 | Request one byte exchange |
| xfer_tx | output | 8 | Byte to send (always 0xFF) |
| xfer_done | input | 1 | Exchange complete; `xfer_rx` is valid |
| xfer_rx | input | 8 | Byte received from the card |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | `out_data` holds a payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| crc_err | output | 1 | CRC mismatch ended the transfer |
| timeout_err | output | 1 | Token hunt ended the transfer |

## Verification
The hardest situation to reach is a failure in the middle of a multi-block transfer while the output stream is being throttled. In that case the error must cut the transfer off right after the low CRC byte of the faulty block, and leave the later blocks in the card's byte stream unread. The bench models the shifter from a byte script holding junk bytes, tokens, payloads and computed CRCs, with one CRC byte corrupted in a chosen block. It then compares the number of bytes actually consumed with the number computed for the truncation point. A second hard case is a stray `start` arriving mid-transfer. The bench injects one with a zero block count, which would finish at once if it were accepted.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_CRCH,
    ST_CRCL
  } sdr_state_e;

  localparam logic [7:0]  START_TOKEN = 8'hFE;
  localparam logic [7:0]  IDLE_BYTE   = 8'hFF;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  // One byte of CRC16 update, MSB of the byte first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                             input logic [7:0]  d_in);
    logic [15:0] c;
    logic [7:0]  d;
    c = c_in;
    d = d_in;
    for (int k = 0; k < 8; k++) begin
      if (c[15] ^ d[7]) c = {c[14:0], 1'b0} ^ CRC_POLY;
      else              c = {c[14:0], 1'b0};
      d = {d[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/sdr_crc16.sv
module sdr_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import sdr_pkg::*;

  logic [15:0] crc_q;
  logic [15:0] crc_d;
  logic        crc_en;

  assign crc_en = clr | upd;

  always_comb begin
    if (clr) crc_d = '0;
    else     crc_d = crc16_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/sdr_out_stage.sv
module sdr_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] data
);

  logic       valid_q;
  logic       valid_d;
  logic [7:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready) valid_d = 1'b0;
    if (load)             valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) data_q <= din;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

endmodule

// File: rtl/sdr_fsm.sv
module sdr_fsm #(
  parameter int CNT_W = 8,
  parameter int SZ_W  = 10,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] blk_count,
  input  logic [SZ_W-1:0]  blk_size,
  input  logic [TO_W-1:0]  to_limit,
  input  logic             crc_chk_en,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx,
  input  logic             out_busy,
  input  logic [15:0]      crc_calc,
  output logic             xfer_req,
  output logic             crc_clr,
  output logic             crc_upd,
  output logic             load,
  output logic             done,
  output logic             crc_err,
  output logic             timeout_err
);
  import sdr_pkg::*;

  sdr_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [SZ_W-1:0]  size_q, size_d;
  logic [SZ_W-1:0]  idx_q, idx_d;
  logic [TO_W-1:0]  lim_q, lim_d;
  logic [TO_W-1:0]  hunt_q, hunt_d;
  logic             chk_q, chk_d;
  logic [7:0]       crch_q, crch_d;
  logic             done_q, done_d;
  logic             cerr_q, cerr_d;
  logic             terr_q, terr_d;

  logic [SZ_W:0]    idx_nxt;
  logic [TO_W:0]    hunt_nxt;
  logic             last_blk;
  logic             crc_bad;

  assign idx_nxt  = {1'b0, idx_q} + (SZ_W+1)'(1);
  assign hunt_nxt = {1'b0, hunt_q} + (TO_W+1)'(1);
  assign last_blk = (left_q == CNT_W'(1));
  assign crc_bad  = chk_q && ({crch_q, xfer_rx} != crc_calc);

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    size_d  = size_q;
    idx_d   = idx_q;
    lim_d   = lim_q;
    hunt_d  = hunt_q;
    chk_d   = chk_q;
    crch_d  = crch_q;
    cerr_d  = cerr_q;
    terr_d  = terr_q;
    done_d  = 1'b0;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          left_d = blk_count;
          size_d = blk_size;
          lim_d  = to_limit;
          chk_d  = crc_chk_en;
          cerr_d = 1'b0;
          terr_d = 1'b0;
          if (blk_count == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_HUNT;
            hunt_d  = '0;
            crc_clr = 1'b1;
          end
        end
      end
      ST_HUNT: begin
        if (xfer_done) begin
          if (xfer_rx == START_TOKEN) begin
            idx_d   = '0;
            state_d = (size_q == '0) ? ST_CRCH : ST_DATA;
          end else if (hunt_nxt >= {1'b0, lim_q}) begin
            terr_d  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            hunt_d = hunt_nxt[TO_W-1:0];
          end
        end
      end
      ST_DATA: begin
        if (xfer_done) begin
          load    = 1'b1;
          crc_upd = 1'b1;
          if (idx_nxt == {1'b0, size_q}) state_d = ST_CRCH;
          else                            idx_d   = idx_nxt[SZ_W-1:0];
        end
      end
      ST_CRCH: begin
        if (xfer_done) begin
          crch_d  = xfer_rx;
          state_d = ST_CRCL;
        end
      end
      ST_CRCL: begin
        if (xfer_done) begin
          if (crc_bad) begin
            cerr_d  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (last_blk) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            left_d  = left_q - CNT_W'(1);
            hunt_d  = '0;
            crc_clr = 1'b1;
            state_d = ST_HUNT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      size_q  <= '0;
      idx_q   <= '0;
      lim_q   <= '0;
      hunt_q  <= '0;
      chk_q   <= 1'b0;
      crch_q  <= '0;
      done_q  <= 1'b0;
      cerr_q  <= 1'b0;
      terr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      size_q  <= size_d;
      idx_q   <= idx_d;
      lim_q   <= lim_d;
      hunt_q  <= hunt_d;
      chk_q   <= chk_d;
      crch_q  <= crch_d;
      done_q  <= done_d;
      cerr_q  <= cerr_d;
      terr_q  <= terr_d;
    end
  end

  assign xfer_req    = (state_q != ST_IDLE) && !out_busy;
  assign done        = done_q;
  assign crc_err     = cerr_q;
  assign timeout_err = terr_q;

endmodule

// File: rtl/sd_blk_reader.sv
module sd_blk_reader #(
  parameter int CNT_W = 8,
  parameter int SZ_W  = 10,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] blk_count,
  input  logic [SZ_W-1:0]  blk_size,
  input  logic [TO_W-1:0]  to_limit,
  input  logic             crc_chk_en,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             crc_err,
  output logic             timeout_err
);
  import sdr_pkg::*;

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_int;
  logic                  crc_clr;
  logic                  crc_upd;
  logic                  load;
  logic [15:0]           crc_calc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[RST_STAGES-1];

  assign xfer_tx = IDLE_BYTE;

  sdr_fsm #(.CNT_W(CNT_W), .SZ_W(SZ_W), .TO_W(TO_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (start),
    .blk_count   (blk_count),
    .blk_size    (blk_size),
    .to_limit    (to_limit),
    .crc_chk_en  (crc_chk_en),
    .xfer_done   (xfer_done),
    .xfer_rx     (xfer_rx),
    .out_busy    (out_valid),
    .crc_calc    (crc_calc),
    .xfer_req    (xfer_req),
    .crc_clr     (crc_clr),
    .crc_upd     (crc_upd),
    .load        (load),
    .done        (done),
    .crc_err     (crc_err),
    .timeout_err (timeout_err)
  );

  sdr_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (crc_clr),
    .upd   (crc_upd),
    .din   (xfer_rx),
    .crc   (crc_calc)
  );

  sdr_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n_int),
    .load  (load),
    .din   (xfer_rx),
    .ready (out_ready),
    .valid (out_valid),
    .data  (out_data)
  );

endmodule

// File: rtl/sdr_checker.sv
module sdr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_req,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done,
  input logic       crc_err,
  input logic       timeout_err
);

  // R5: no exchange while a payload byte waits
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !xfer_req);

  // R4: held byte stays put until taken
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: done lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: nothing requested once finished
  assert_idle_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_req);

  // R6: crc error appears together with done
  assert_crc_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> done);

  // R3: timeout appears together with done
  assert_to_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);

  // R3/R6: one failure cause per transfer
  assert_one_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_err && timeout_err));

endmodule

bind sd_blk_reader sdr_checker u_sdr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_req    (xfer_req),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .done        (done),
  .crc_err     (crc_err),
  .timeout_err (timeout_err)
);

// File: tb/sd_blk_reader_bench.sv
`timescale 1ns/1ps
module sd_blk_reader_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  blk_count;
  logic [9:0]  blk_size;
  logic [15:0] to_limit;
  logic        crc_chk_en;
  logic        xfer_req;
  logic [7:0]  xfer_tx;
  logic        xfer_done;
  logic [7:0]  xfer_rx;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic        done;
  logic        crc_err;
  logic        timeout_err;

  sd_blk_reader u_sd_blk_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
    .blk_size(blk_size), .to_limit(to_limit), .crc_chk_en(crc_chk_en),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
    .xfer_rx(xfer_rx), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .crc_err(crc_err),
    .timeout_err(timeout_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // card byte script and shifter model
  logic [7:0] feed [0:2047];
  int wp = 0;
  int feed_len = 0;
  int rd_ptr;
  int scnt;
  logic sbusy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbusy <= 1'b0; scnt <= 0; xfer_done <= 1'b0; xfer_rx <= 8'hFF; rd_ptr <= 0;
    end else begin
      xfer_done <= 1'b0;
      if (sbusy) begin
        if (scnt == 0) begin
          xfer_done <= 1'b1;
          xfer_rx   <= (rd_ptr < feed_len) ? feed[rd_ptr] : 8'hFF;
          rd_ptr    <= rd_ptr + 1;
          sbusy     <= 1'b0;
        end else scnt <= scnt - 1;
      end else if (xfer_req && !xfer_done) begin
        sbusy <= 1'b1; scnt <= 2;
      end
    end
  end

  // output collector and ready pattern
  logic [7:0] got  [0:2047];
  logic [7:0] expq [0:2047];
  int got_n = 0;
  int exp_n = 0;
  int bp_mode = 0;
  int rcnt = 0;

  always @(posedge clk)
    if (out_valid && out_ready) begin
      got[got_n] <= out_data;
      got_n <= got_n + 1;
    end

  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    case (bp_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= (rcnt % 3) != 0;
      2: out_ready <= (rcnt % 5) == 0;
      default: out_ready <= 1'b0;
    endcase
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[15] ^ d[k]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] b);
    feed[wp] = b; wp++; feed_len = wp;
  endtask

  task automatic add_block(input int fill, input logic [7:0] fv, input int size,
                           input int seed, input bit bad);
    logic [15:0] c;
    logic [7:0] b;
    c = 16'h0;
    for (int i = 0; i < fill; i++) put(fv);
    put(8'hFE);
    for (int i = 0; i < size; i++) begin
      b = 8'((seed * 29 + i * 13 + 7) & 255);
      put(b);
      expq[exp_n] = b; exp_n++;
      c = ref_crc(c, b);
    end
    put(c[15:8]);
    put(c[7:0] ^ (bad ? 8'h01 : 8'h00));
  endtask

  int pbase, gbase;

  task automatic begin_test();
    wp = rd_ptr; feed_len = wp; exp_n = 0; pbase = rd_ptr; gbase = got_n;
  endtask

  task automatic pulse_start(input int cnt, input int size, input int lim, input bit ce);
    @(negedge clk);
    blk_count = 8'(cnt); blk_size = 10'(size); to_limit = 16'(lim); crc_chk_en = ce;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic verify(input string req, input int cons, input bit ecrc, input bit eto,
                        input int nbytes);
    int bad;
    chk(rd_ptr - pbase == cons, req, "bytes consumed", rd_ptr - pbase, cons);
    chk(crc_err == ecrc, req, "crc_err", crc_err, ecrc);
    chk(timeout_err == eto, req, "timeout_err", timeout_err, eto);
    chk(got_n - gbase == nbytes, req, "payload count", got_n - gbase, nbytes);
    bad = 0;
    for (int i = 0; i < nbytes && i < got_n - gbase; i++)
      if (got[gbase + i] !== expq[i]) bad++;
    chk(bad == 0, req, "payload mismatches", bad, 0);
  endtask

  task automatic run_all();
    int cons;
    bit early;
    // R1 reset state
    chk(xfer_req == 1'b0, "R1", "xfer_req", xfer_req, 0);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(crc_err == 1'b0 && timeout_err == 1'b0, "R1", "flags", crc_err + timeout_err, 0);
    chk(xfer_tx == 8'hFF, "R1", "xfer_tx", xfer_tx, 255);

    // R2 R4 single block with junk before the token
    begin_test();
    add_block(3, 8'h01, 4, 1, 0);
    pulse_start(1, 4, 10, 1'b1); wait_done();
    verify("R2", wp - pbase, 0, 0, 4);

    // R8 R4 sweep of sizes and counts, varied backpressure
    for (int sz = 1; sz <= 6; sz++)
      for (int cn = 1; cn <= 3; cn++) begin
        bp_mode = (sz + cn) % 3;
        begin_test();
        for (int b = 0; b < cn; b++) add_block((sz + b) % 3, 8'hFF, sz, sz * 7 + b, 0);
        pulse_start(cn, sz, 8, 1'b1); wait_done();
        verify("R8", wp - pbase, 0, 0, sz * cn);
      end
    bp_mode = 0;

    // R6 bad crc in block 2 of 3: stop right after it
    bp_mode = 1;
    begin_test();
    add_block(1, 8'hFF, 5, 40, 0);
    add_block(2, 8'hFF, 5, 41, 1);
    cons = wp - pbase;
    add_block(0, 8'hFF, 5, 42, 0);
    pulse_start(3, 5, 8, 1'b1); wait_done();
    verify("R6", cons, 1, 0, 10);
    bp_mode = 0;

    // R8 flags cleared by the next accepted start
    begin_test();
    add_block(0, 8'hFF, 2, 50, 0);
    pulse_start(1, 2, 8, 1'b1); wait_done();
    verify("R8", wp - pbase, 0, 0, 2);

    // R7 bad crc ignored when checking is off
    begin_test();
    add_block(1, 8'hFF, 3, 60, 1);
    add_block(1, 8'hFF, 3, 61, 1);
    pulse_start(2, 3, 8, 1'b0); wait_done();
    verify("R7", wp - pbase, 0, 0, 6);

    // R3 token never arrives within limit 5
    begin_test();
    add_block(5, 8'hFF, 3, 70, 0);
    pulse_start(1, 3, 5, 1'b1); wait_done();
    verify("R3", 5, 0, 1, 0);

    // R3 token as the last allowed byte
    begin_test();
    add_block(4, 8'hFF, 3, 71, 0);
    pulse_start(1, 3, 5, 1'b1); wait_done();
    verify("R3", wp - pbase, 0, 0, 3);

    // R3 limit 0 behaves like 1
    begin_test();
    add_block(1, 8'hFF, 3, 72, 0);
    pulse_start(1, 3, 0, 1'b1); wait_done();
    verify("R3", 1, 0, 1, 0);

    // R9 zero block count
    begin_test();
    add_block(0, 8'hFF, 3, 80, 0);
    pulse_start(0, 3, 8, 1'b1);
    chk(done == 1'b1, "R9", "done after start", done, 1);
    repeat (12) @(negedge clk);
    verify("R9", 0, 0, 0, 0);

    // R5 R4 output stalled: exchanges stop, byte held
    bp_mode = 3;
    begin_test();
    add_block(2, 8'hFF, 4, 90, 0);
    pulse_start(1, 4, 8, 1'b1);
    repeat (60) @(negedge clk);
    chk(rd_ptr - pbase == 4, "R5", "consumed while stalled", rd_ptr - pbase, 4);
    chk(out_valid == 1'b1, "R4", "valid while stalled", out_valid, 1);
    chk(out_data == expq[0], "R4", "held data", out_data, expq[0]);
    bp_mode = 0;
    wait_done();
    verify("R5", wp - pbase, 0, 0, 4);

    // R10 stray start mid-transfer is ignored
    bp_mode = 2;
    begin_test();
    add_block(1, 8'hFF, 5, 100, 0);
    add_block(1, 8'hFF, 5, 101, 0);
    pulse_start(2, 5, 8, 1'b1);
    early = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) early = 1;
    end
    pulse_start(0, 1, 1, 1'b1);
    if (done) early = 1;
    chk(!early, "R10", "early done", early, 0);
    wait_done();
    verify("R10", wp - pbase, 0, 0, 10);
    bp_mode = 0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; blk_count = '0; blk_size = '0;
    to_limit = '0; crc_chk_en = 1'b1; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule